// File: doc/BRIEF.md
# Multi-Size Shift and Rotate Execution Unit

This unit carries out the shift group of a memory-to-memory processor. Each instruction names one of four operand sizes and one of seven operations in its opcode byte. The shift count comes from the instruction's source field. The operand is the value read from the destination location. The unit returns the value to write back to that location, together with the new carry flag.

The operations are logical left and right shifts, arithmetic right shift, plain rotates, and rotates that pass through the carry flag. All of them are available at 8, 16, 32 and 64 bits. One parallel lane is built per size, and the opcode picks which lane drives the result. Result, carry and the illegal-opcode flag are registered. They load on any cycle where `op_valid` is high and hold otherwise.

Top module: `shr_unit`

## Requirements
- R1: `opcode[4:3]` selects the size: 00 = 8 bits, 01 = 16, 10 = 32, 11 = 64. Operand bits above the selected size are ignored, and the result is zero-extended to 64 bits.
- R2: `opcode[7:5]` must be 111. `opcode[2:0]` picks the operation: 0 shift left, 1 shift right (logical), 3 arithmetic shift right, 4 rotate left, 5 rotate right, 6 rotate left through carry, 7 rotate right through carry.
- R3: For logical shifts with a count from 1 to the width, carry takes the last bit shifted out; a count equal to the width gives zero with the edge bit in carry. A count above the width gives zero result and zero carry.
- R4: Arithmetic right shift fills with the sign bit, and carry takes the last bit shifted out. Any count of at least the width gives all sign bits, with the sign in carry.
- R5: Plain rotates use the count modulo the width. After a nonzero count, carry equals the bit that wrapped last: result bit 0 for rotate left, the top result bit for rotate right.
- R6: Rotates through carry treat carry and operand as a ring of width+1 bits, with carry next above the operand MSB. The count is taken modulo width+1.
- R7: A count of zero returns the operand (size-masked, zero-extended) and leaves carry equal to `carry_in`.
- R8: `opcode[2:0]` = 2, or `opcode[7:5]` other than 111, sets `illegal`. The result is then the full 64-bit operand unchanged, and carry equals `carry_in`.
- R9: Outputs take new values at the clock edge where `op_valid` is high, and `res_valid` is high for the following cycle. With `op_valid` low, result, carry and illegal hold and `res_valid` is low.
- R10: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Load enable for a new operation |
| opcode | input | 8 | Shift-group opcode byte |
| count | input | CNT_W (8) | Shift or rotate count from the source field |
| operand | input | 64 | Value read from the destination location |
| carry_in | input | 1 | Current carry flag |
| res_valid | output | 1 | A result was loaded on the previous edge |
| result | output | 64 | Value to write back, zero-extended |
| carry_out | output | 1 | Updated carry flag |
| illegal | output | 1 | Opcode not part of the shift group |

## Verification
The result and the carry flag are produced in the same cycle from the same count. The hardest case is a count at or just past a boundary: equal to the width, one above it, or a multiple of width or width+1 for rotates. At those counts the result clears, fills or wraps in the very cycle that carry picks up an edge bit, is forced to zero, or is left alone. The vector table places such counts at every size, with upper operand bits set and carry preset to the opposite value. Both outputs are compared in the single cycle after the load. A directed back-to-back case issues a legal operation and then an illegal opcode on consecutive edges, to confirm that the pass-through path replaces the lane result without a stale carry.

// File: rtl/shr_pkg.sv
package shr_pkg;
  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_RSV = 3'd2,
    OP_ASR = 3'd3,
    OP_ROL = 3'd4,
    OP_ROR = 3'd5,
    OP_RLC = 3'd6,
    OP_RRC = 3'd7
  } shr_op_e;

  localparam int NUM_SIZES = 4;
  localparam logic [2:0] GROUP_TAG = 3'b111;
endpackage

// File: rtl/shr_decode.sv
module shr_decode
  import shr_pkg::*;
(
  input  logic [7:0] opcode,
  output shr_op_e    op,
  output logic [1:0] size_sel,
  output logic       bad_op
);
  always_comb begin
    op       = shr_op_e'(opcode[2:0]);
    size_sel = opcode[4:3];
    bad_op   = (opcode[7:5] != GROUP_TAG) || (opcode[2:0] == OP_RSV);
  end
endmodule

// File: rtl/shr_lane.sv
module shr_lane
  import shr_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 8
) (
  input  shr_op_e          op,
  input  logic [CNT_W-1:0] cnt,
  input  logic [W-1:0]     x,
  input  logic             ci,
  output logic [W-1:0]     res,
  output logic             co
);
  localparam int RW = W + 1;

  logic [RW-1:0]        sl_t;
  logic [RW-1:0]        sr_t;
  logic signed [RW-1:0] as_t;
  logic [W-1:0]         rot_l;
  logic [W-1:0]         rot_r;
  logic [RW-1:0]        ring;
  logic [RW-1:0]        ring_l;
  logic [RW-1:0]        ring_r;
  int                   n_cap;
  int                   k_rot;
  int                   k_ring;

  always_comb begin
    n_cap  = (int'(cnt) > W) ? W : int'(cnt);
    k_rot  = int'(cnt) % W;
    k_ring = int'(cnt) % RW;
    // logical shifts keep one guard bit to catch the last bit out
    sl_t   = {1'b0, x} << cnt;
    sr_t   = {x, 1'b0} >> cnt;
    as_t   = $signed({x, 1'b0}) >>> n_cap;
    rot_l  = (x << k_rot) | (x >> (W - k_rot));
    rot_r  = (x >> k_rot) | (x << (W - k_rot));
    ring   = {ci, x};
    ring_l = (ring << k_ring) | (ring >> (RW - k_ring));
    ring_r = (ring >> k_ring) | (ring << (RW - k_ring));
  end

  always_comb begin
    res = x;
    co  = ci;
    if (cnt != '0) begin
      unique case (op)
        OP_SHL: begin res = sl_t[W-1:0];   co = sl_t[W];     end
        OP_SHR: begin res = sr_t[W:1];     co = sr_t[0];     end
        OP_ASR: begin res = as_t[W:1];     co = as_t[0];     end
        OP_ROL: begin res = rot_l;         co = rot_l[0];    end
        OP_ROR: begin res = rot_r;         co = rot_r[W-1];  end
        OP_RLC: begin res = ring_l[W-1:0]; co = ring_l[W];   end
        OP_RRC: begin res = ring_r[W-1:0]; co = ring_r[W];   end
        default: begin res = x;            co = ci;          end
      endcase
    end
  end
endmodule

// File: rtl/shr_unit.sv
module shr_unit
  import shr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [7:0]          opcode,
  input  logic [CNT_W-1:0]    count,
  input  logic [BYTE_W*8-1:0] operand,
  input  logic                carry_in,
  output logic                res_valid,
  output logic [BYTE_W*8-1:0] result,
  output logic                carry_out,
  output logic                illegal
);
  localparam int DATA_W = BYTE_W * 8;

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  shr_op_e    dec_op;
  logic [1:0] dec_size;
  logic       dec_bad;

  shr_decode u_dec (
    .opcode   (opcode),
    .op       (dec_op),
    .size_sel (dec_size),
    .bad_op   (dec_bad)
  );

  logic [DATA_W-1:0] lane_res [NUM_SIZES];
  logic              lane_co  [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int LW = BYTE_W << g;
    logic [LW-1:0] lres;
    logic          lco;
    shr_lane #(.W(LW), .CNT_W(CNT_W)) u_lane (
      .op  (dec_op),
      .cnt (count),
      .x   (operand[LW-1:0]),
      .ci  (carry_in),
      .res (lres),
      .co  (lco)
    );
    assign lane_res[g] = DATA_W'(lres);
    assign lane_co[g]  = lco;
  end

  logic [DATA_W-1:0] res_d;
  logic              co_d;
  logic              ill_d;

  always_comb begin
    ill_d = dec_bad;
    if (dec_bad) begin
      res_d = operand;
      co_d  = carry_in;
    end else begin
      res_d = lane_res[dec_size];
      co_d  = lane_co[dec_size];
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      res_valid <= 1'b0;
      result    <= '0;
      carry_out <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        result    <= res_d;
        carry_out <= co_d;
        illegal   <= ill_d;
      end
    end
  end

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !op_valid |=> ($stable(result) && $stable(carry_out) && $stable(illegal) && !res_valid));

  assert_illegal_passthru_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_valid && dec_bad) |=> (illegal && result == $past(operand) && carry_out == $past(carry_in)));

  assert_zero_count_carry_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_valid && !dec_bad && count == '0) |=> (carry_out == $past(carry_in)));

  assert_byte_zext_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_valid && !dec_bad && opcode[4:3] == 2'b00) |=> (result[DATA_W-1:BYTE_W] == '0));

  assert_wide_logical_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_valid && !dec_bad && opcode[2:1] == 2'b00 && int'(count) > DATA_W)
    |=> (result == '0 && !carry_out));

  assert_asr_fill_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_valid && opcode == 8'hFB && int'(count) >= DATA_W)
    |=> (result == {DATA_W{$past(operand[DATA_W-1])}} && carry_out == $past(operand[DATA_W-1])));
endmodule

// File: tb/shr_unit_test.sv
`timescale 1ns/1ps
module shr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  count = 8'h00;
  logic [63:0] operand = 64'h0;
  logic        carry_in = 1'b0;
  logic        res_valid;
  logic [63:0] result;
  logic        carry_out;
  logic        illegal;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  shr_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .count(count), .operand(operand), .carry_in(carry_in),
    .res_valid(res_valid), .result(result), .carry_out(carry_out),
    .illegal(illegal)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic [7:0]  cnt;
    logic [63:0] x;
    logic        ci;
    logic [63:0] r;
    logic        co;
    logic        il;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{8'hE0, 8'd3,  64'hFFFF_FFFF_FFFF_FFA5, 1'b0, 64'h28, 1'b1, 1'b0, 4'd1},  // R1 byte mask
    '{8'hE1, 8'd1,  64'h81, 1'b0, 64'h40, 1'b1, 1'b0, 4'd3},                   // R3
    '{8'hE1, 8'd8,  64'h81, 1'b0, 64'h0,  1'b1, 1'b0, 4'd3},                   // R3 count==width
    '{8'hE0, 8'd9,  64'hFF, 1'b1, 64'h0,  1'b0, 1'b0, 4'd3},                   // R3 count>width
    '{8'hE3, 8'd2,  64'h84, 1'b1, 64'hE1, 1'b0, 1'b0, 4'd4},                   // R4
    '{8'hE3, 8'd20, 64'h80, 1'b0, 64'hFF, 1'b1, 1'b0, 4'd4},                   // R4 saturate
    '{8'hE4, 8'd1,  64'h81, 1'b0, 64'h03, 1'b1, 1'b0, 4'd5},                   // R5
    '{8'hE5, 8'd9,  64'h01, 1'b0, 64'h80, 1'b1, 1'b0, 4'd5},                   // R5 modulo
    '{8'hE6, 8'd1,  64'h80, 1'b0, 64'h00, 1'b1, 1'b0, 4'd6},                   // R6
    '{8'hE6, 8'd9,  64'h5A, 1'b1, 64'h5A, 1'b1, 1'b0, 4'd6},                   // R6 full ring
    '{8'hE7, 8'd1,  64'h01, 1'b1, 64'h80, 1'b1, 1'b0, 4'd6},                   // R6
    '{8'hEF, 8'd2,  64'h0003, 1'b0, 64'h8000, 1'b1, 1'b0, 4'd6},               // R6 half
    '{8'hE8, 8'd4,  64'hF234, 1'b0, 64'h2340, 1'b1, 1'b0, 4'd3},               // R3 half
    '{8'hEC, 8'd20, 64'h1234, 1'b0, 64'h2341, 1'b1, 1'b0, 4'd5},               // R5 half
    '{8'hF0, 8'd31, 64'hFFFF_FFFF_0000_0003, 1'b0, 64'h8000_0000, 1'b1, 1'b0, 4'd1}, // R1 word
    '{8'hF3, 8'd4,  64'h8000_0010, 1'b1, 64'hF800_0001, 1'b0, 1'b0, 4'd4},     // R4 word
    '{8'hF5, 8'd33, 64'h2, 1'b1, 64'h1, 1'b0, 1'b0, 4'd5},                     // R5 word
    '{8'hF8, 8'd64, 64'h8000_0000_0000_0001, 1'b0, 64'h0, 1'b1, 1'b0, 4'd3},   // R3 long
    '{8'hF9, 8'd1,  64'h8000_0000_0000_0003, 1'b0, 64'h4000_0000_0000_0001, 1'b1, 1'b0, 4'd3}, // R3
    '{8'hFB, 8'd63, 64'h8000_0000_0000_0000, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 4'd4}, // R4
    '{8'hFE, 8'd65, 64'h0123_4567_89AB_CDEF, 1'b0, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0, 4'd6}, // R6
    '{8'hFF, 8'd1,  64'h2, 1'b1, 64'h8000_0000_0000_0001, 1'b0, 1'b0, 4'd6},   // R6 long
    '{8'hFC, 8'd4,  64'hF000_0000_0000_000F, 1'b0, 64'hFF, 1'b1, 1'b0, 4'd5},  // R5 long
    '{8'hE0, 8'd0,  64'hABCD_0000_0000_00C3, 1'b1, 64'hC3, 1'b1, 1'b0, 4'd7},  // R7
    '{8'hF9, 8'd0,  64'h55, 1'b0, 64'h55, 1'b0, 1'b0, 4'd7},                   // R7
    '{8'hE2, 8'd3,  64'hDEAD_BEEF_0000_1111, 1'b1, 64'hDEAD_BEEF_0000_1111, 1'b1, 1'b1, 4'd8}, // R8
    '{8'hFA, 8'd1,  64'h1234, 1'b0, 64'h1234, 1'b0, 1'b1, 4'd8},               // R8
    '{8'h48, 8'd2,  64'h77, 1'b1, 64'h77, 1'b1, 1'b1, 4'd2},                   // R2 outside group
    '{8'hC0, 8'd1,  64'h3, 1'b0, 64'h3, 1'b0, 1'b1, 4'd2}                      // R2 outside group
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] op, input logic [7:0] cnt,
                      input logic [63:0] x, input logic ci);
    @(negedge clk);
    opcode = op; count = cnt; operand = x; carry_in = ci; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs zero while reset held
    check("R10 result", result, 64'h0);
    check("R10 flags", {61'h0, res_valid, carry_out, illegal}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      load(VEC[i].op, VEC[i].cnt, VEC[i].x, VEC[i].ci);
      check($sformatf("R%0d vec%0d result", VEC[i].rq, i), result, VEC[i].r);
      check($sformatf("R%0d vec%0d carry", VEC[i].rq, i), {63'h0, carry_out}, {63'h0, VEC[i].co});
      check($sformatf("R%0d vec%0d illegal", VEC[i].rq, i), {63'h0, illegal}, {63'h0, VEC[i].il});
      check($sformatf("R9 vec%0d valid", i), {63'h0, res_valid}, 64'h1);
    end

    // R9: idle cycle with changed inputs holds every output
    load(8'hE4, 8'd1, 64'h81, 1'b0);
    @(negedge clk);
    opcode = 8'hF8; count = 8'd2; operand = 64'hFFFF; carry_in = 1'b0;
    @(negedge clk);
    check("R9 hold result", result, 64'h03);
    check("R9 hold carry", {63'h0, carry_out}, 64'h1);
    check("R9 valid low", {63'h0, res_valid}, 64'h0);

    // R8 back to back: legal shift then illegal opcode on consecutive edges
    @(negedge clk);
    opcode = 8'hF8; count = 8'd1; operand = 64'h8000_0000_0000_0000; carry_in = 1'b0; op_valid = 1'b1;
    @(negedge clk);
    check("R3 b2b first result", result, 64'h0);
    check("R3 b2b first carry", {63'h0, carry_out}, 64'h1);
    opcode = 8'hEA; count = 8'd5; operand = 64'h0F0F; carry_in = 1'b0;
    @(negedge clk);
    op_valid = 1'b0;
    check("R8 b2b result", result, 64'h0F0F);
    check("R8 b2b carry", {63'h0, carry_out}, 64'h0);
    check("R8 b2b illegal", {63'h0, illegal}, 64'h1);

    // R10: asynchronous reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 async result", result, 64'h0);
    check("R10 async illegal", {63'h0, illegal}, 64'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule